// File: doc/BRIEF.md
# Receive FIFO Forwarding Gate

This block sits between the byte stream coming out of an Ethernet receive MAC and the receive DMA engine. Bytes are written into an internal FIFO as they arrive. The gate decides when the bytes of a frame become visible to the DMA read side, and which frames are thrown away instead. It keeps a byte count for the frame being received, the address-filter verdict for that frame (which may arrive at any byte of the frame), and the FIFO position where the frame started.

There are two release policies. In store-and-forward mode a frame becomes readable only once its final byte is stored. In cut-through mode it becomes readable as soon as its byte count reaches a programmable threshold and the filter has accepted it. The threshold is 32, 64, 96 or 128 bytes. A frame that the filter rejects, that has no verdict by its final byte, that overflows the FIFO, or that software flushes is removed by moving the write pointer back to the frame's start. The one exception is a cut-through frame whose bytes the DMA may already hold: such a frame is closed with an error terminator word instead.

The read side gives the DMA a registered "data available" flag and a synchronous read port. One cycle after an accepted read request, the port returns a byte together with end-of-frame and error flags.

Top module: `rxq_fwd_gate`

## Requirements
- R1: After reset, frame_avail, rd_dv and drop_pulse are all low and the FIFO holds no readable data.
- R2: In store-and-forward mode (cfg_cut_thru=0), frame_avail stays low while an accepted frame is arriving. It rises in the cycle after the clock edge that stores the frame's final byte.
- R3: In cut-through mode (cfg_cut_thru=1), the threshold T is 32*(cfg_thr_sel+1), so encodings 0,1,2,3 give 32,64,96,128 bytes. An accepted frame becomes readable after the edge that stores byte number T. A frame shorter than T becomes readable after the edge that stores its final byte. The release point never runs ahead of the written data.
- R4: In cut-through mode, nothing of a frame is released before its verdict is known. If the accepting verdict arrives after byte T, release happens at the edge that takes the verdict.
- R5: A frame is discarded and never becomes readable if flt_valid arrives with flt_pass=0, or if no verdict has arrived by its final byte. drop_pulse is high for exactly one cycle for each discarded frame.
- R6: A one-cycle flush_req during a frame discards that frame's stored bytes, ignores its remaining bytes up to and including wr_last, and pulses drop_pulse. A flush_req between frames has no effect.
- R7: A byte that arrives while the FIFO holds its full depth, in a frame not yet released, drops the whole frame (rewind, one drop_pulse, rest of frame ignored). The FIFO never holds more than its depth.
- R8: If that overflow hits a cut-through frame that is already released, the bytes already stored stay readable. As soon as one slot frees, a terminator word is appended with rd_err=1, rd_last=1 and rd_data=0. The frame's remaining bytes are ignored.
- R9: rd_en while frame_avail is high returns the next stored byte on rd_data in the following cycle, with rd_dv high. Bytes come out in arrival order, and rd_last is high only on a frame's final byte. rd_en while frame_avail is low produces no rd_dv.
- R10: Mode and threshold are sampled on the first byte of a frame. Changing them later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cut_thru | input | 1 | 1 = cut-through release, 0 = store-and-forward |
| cfg_thr_sel | input | 2 | Cut-through threshold select: 32*(value+1) bytes |
| flush_req | input | 1 | Discard the frame currently being received |
| wr_valid | input | 1 | A received byte is on wr_data |
| wr_data | input | DW | Received byte |
| wr_last | input | 1 | This byte ends the frame |
| flt_valid | input | 1 | Address-filter verdict is present this cycle |
| flt_pass | input | 1 | Verdict: 1 accept, 0 reject |
| rd_en | input | 1 | DMA read request |
| rd_dv | output | 1 | rd_data/rd_last/rd_err hold a returned word |
| rd_data | output | DW | Returned byte |
| rd_last | output | 1 | Returned byte ends a frame |
| rd_err | output | 1 | Returned word is an error terminator |
| frame_avail | output | 1 | Released data is waiting to be read |
| drop_pulse | output | 1 | One-cycle pulse per discarded frame |

## Verification
A bad frame-start pointer shows up on the read side. The next frame drained after a discard carries stale or missing bytes, which is visible within one frame's drain. A wrong release pointer or a wrong threshold latch moves the cycle in which frame_avail rises. The bench therefore records, for each frame, the exact byte index at which the flag first goes high. A stuck state in the write controller shows up as a frame that never becomes readable, or as a missing or extra drop_pulse. An error in the overflow path shows up as a wrong word count, or as a missing terminator flag, at the end of an overflowed drain.

// File: rtl/rxq_fwd_pkg.sv
package rxq_fwd_pkg;

  // Write-side controller states
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,   // between frames
    WS_RECV = 2'd1,   // storing bytes of the current frame
    WS_SKIP = 2'd2,   // dropping the rest of an aborted frame
    WS_TERM = 2'd3    // waiting for a slot to append an error terminator
  } wr_state_e;

endpackage

// File: rtl/rxq_fifo_ram.sv
module rxq_fifo_ram #(
  parameter int AW = 8,
  parameter int WW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rdata_q;

  // Simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
  import rxq_fwd_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 8,
  parameter int THR_STEP = 32,
  parameter int PW       = AW + 1,
  parameter int WW       = DW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cut_thru,
  input  logic [1:0]    cfg_thr_sel,
  input  logic          flush_req,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          flt_valid,
  input  logic          flt_pass,
  input  logic [PW-1:0] rd_ptr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [WW-1:0] mem_wdata,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rel_ptr,
  output logic [PW-1:0] rel_nxt,
  output logic          drop_pulse,
  output wr_state_e     state,
  output logic          known,
  output logic          cut_act
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  wr_state_e     st_q, st_n;
  logic [PW-1:0] wr_q, wr_n, start_q, start_n, rel_q, rel_n;
  logic [PW-1:0] cnt_q, cnt_n, thr_q, thr_n, thr_cfg;
  logic          known_q, known_n, pass_q, pass_n;
  logic          released_q, released_n, cut_q, cut_n;
  logic          lseen_q, lseen_n, drop_q, drop_n;
  logic          full, fresh, ending, we;
  logic [WW-1:0] wdata;

  assign thr_cfg = PW'((int'(cfg_thr_sel) + 1) * THR_STEP);
  assign full    = (wr_q - rd_ptr) == DEPTH_P;
  assign fresh   = (st_q == WS_IDLE) && wr_valid;
  assign ending  = wr_valid && wr_last;

  always_comb begin
    st_n       = st_q;
    wr_n       = wr_q;
    start_n    = start_q;
    rel_n      = rel_q;
    cnt_n      = cnt_q;
    thr_n      = thr_q;
    known_n    = known_q;
    pass_n     = pass_q;
    released_n = released_q;
    cut_n      = cut_q;
    lseen_n    = lseen_q;
    drop_n     = 1'b0;
    we         = 1'b0;
    wdata      = '0;

    // First byte of a frame: latch the policy and clear the frame context
    if (fresh) begin
      cut_n      = cfg_cut_thru;
      thr_n      = thr_cfg;
      cnt_n      = '0;
      known_n    = 1'b0;
      pass_n     = 1'b0;
      released_n = 1'b0;
      start_n    = wr_q;
    end

    if (st_q == WS_RECV || fresh) begin
      if (flt_valid && !known_n) begin
        known_n = 1'b1;
        pass_n  = flt_pass;
      end
      if (flush_req || (wr_valid && full) || (known_n && !pass_n)) begin
        drop_n = 1'b1;
        if (released_n) begin
          st_n    = WS_TERM;
          lseen_n = ending;
        end else begin
          wr_n = start_n;
          st_n = ending ? WS_IDLE : WS_SKIP;
        end
      end else if (wr_valid) begin
        we    = 1'b1;
        wdata = {1'b0, wr_last, wr_data};
        wr_n  = wr_q + PW'(1);
        if (cnt_n != '1) cnt_n = cnt_n + PW'(1);
        if (wr_last) begin
          st_n = WS_IDLE;
          if (known_n) begin
            rel_n = wr_n;
          end else begin
            drop_n = 1'b1;   // no verdict by the final byte
            wr_n   = start_n;
          end
        end else begin
          st_n = WS_RECV;
        end
      end
      // Cut-through release: threshold reached and frame accepted
      if (st_n == WS_RECV && cut_n && known_n && pass_n && cnt_n >= thr_n) begin
        rel_n      = wr_n;
        released_n = 1'b1;
      end
    end else if (st_q == WS_SKIP) begin
      if (ending) st_n = WS_IDLE;
    end else if (st_q == WS_TERM) begin
      if (ending) lseen_n = 1'b1;
      if (!full) begin
        we    = 1'b1;
        wdata = {1'b1, 1'b1, {DW{1'b0}}};
        wr_n  = wr_q + PW'(1);
        rel_n = wr_n;
        st_n  = lseen_n ? WS_IDLE : WS_SKIP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= WS_IDLE;
      wr_q       <= '0;
      start_q    <= '0;
      rel_q      <= '0;
      cnt_q      <= '0;
      thr_q      <= '0;
      known_q    <= 1'b0;
      pass_q     <= 1'b0;
      released_q <= 1'b0;
      cut_q      <= 1'b0;
      lseen_q    <= 1'b0;
      drop_q     <= 1'b0;
    end else begin
      st_q       <= st_n;
      wr_q       <= wr_n;
      start_q    <= start_n;
      rel_q      <= rel_n;
      cnt_q      <= cnt_n;
      thr_q      <= thr_n;
      known_q    <= known_n;
      pass_q     <= pass_n;
      released_q <= released_n;
      cut_q      <= cut_n;
      lseen_q    <= lseen_n;
      drop_q     <= drop_n;
    end
  end

  assign mem_we     = we;
  assign mem_waddr  = wr_q[AW-1:0];
  assign mem_wdata  = wdata;
  assign wr_ptr     = wr_q;
  assign rel_ptr    = rel_q;
  assign rel_nxt    = rel_n;
  assign drop_pulse = drop_q;
  assign state      = st_q;
  assign known      = known_q;
  assign cut_act    = cut_q;

endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl #(
  parameter int AW = 8,
  parameter int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [PW-1:0] rel_nxt,
  output logic [PW-1:0] rd_ptr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          frame_avail,
  output logic          rd_dv
);

  logic [PW-1:0] rd_q, rd_n;
  logic          avail_q, dv_q, take;

  assign take = rd_en && avail_q;
  assign rd_n = rd_q + PW'(take);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= '0;
      avail_q <= 1'b0;
      dv_q    <= 1'b0;
    end else begin
      rd_q    <= rd_n;
      avail_q <= rel_nxt != rd_n;
      dv_q    <= take;
    end
  end

  assign rd_ptr      = rd_q;
  assign mem_re      = take;
  assign mem_raddr   = rd_q[AW-1:0];
  assign frame_avail = avail_q;
  assign rd_dv       = dv_q;

endmodule

// File: rtl/rxq_fwd_gate.sv
module rxq_fwd_gate
  import rxq_fwd_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DW       = 8,
  parameter int THR_STEP = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_cut_thru,
  input  logic [1:0]    cfg_thr_sel,
  input  logic          flush_req,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          flt_valid,
  input  logic          flt_pass,
  input  logic          rd_en,
  output logic          rd_dv,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic          rd_err,
  output logic          frame_avail,
  output logic          drop_pulse
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int WW = DW + 2;

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [WW-1:0] mem_wdata, mem_rdata;
  logic [PW-1:0] wr_ptr_w, rel_ptr_w, rel_nxt_w, rd_ptr_w;
  wr_state_e     st_w;
  logic          known_w, cut_w;

  rxq_wr_ctrl #(
    .AW(AW), .DW(DW), .THR_STEP(THR_STEP), .PW(PW), .WW(WW)
  ) u_wr (
    .clk(clk), .rst(rst),
    .cfg_cut_thru(cfg_cut_thru), .cfg_thr_sel(cfg_thr_sel),
    .flush_req(flush_req),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .flt_valid(flt_valid), .flt_pass(flt_pass),
    .rd_ptr(rd_ptr_w),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr_w), .rel_ptr(rel_ptr_w), .rel_nxt(rel_nxt_w),
    .drop_pulse(drop_pulse),
    .state(st_w), .known(known_w), .cut_act(cut_w)
  );

  rxq_rd_ctrl #(
    .AW(AW), .PW(PW)
  ) u_rd (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rel_nxt(rel_nxt_w),
    .rd_ptr(rd_ptr_w), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .frame_avail(frame_avail), .rd_dv(rd_dv)
  );

  rxq_fifo_ram #(
    .AW(AW), .WW(WW)
  ) u_ram (
    .clk(clk),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign rd_data = mem_rdata[DW-1:0];
  assign rd_last = mem_rdata[DW];
  assign rd_err  = mem_rdata[DW+1];

endmodule

// File: rtl/rxq_fwd_gate_chk.sv
module rxq_fwd_gate_chk
  import rxq_fwd_pkg::*;
#(
  parameter int PW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_avail,
  input logic          rd_dv,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rel_ptr,
  input logic [PW-1:0] rd_ptr,
  input wr_state_e     state,
  input logic          known,
  input logic          cut_act
);

  localparam logic [PW-1:0] DEPTH_P = PW'(1) << (PW - 1);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - rd_ptr) <= DEPTH_P);  // R7

  AST_REL_BEHIND_WR: assert property (@(posedge clk) disable iff (rst)
    ((wr_ptr - rel_ptr) <= DEPTH_P) && ((rel_ptr - rd_ptr) <= DEPTH_P));  // R3

  AST_SAF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == WS_RECV && !cut_act) |-> $stable(rel_ptr));  // R2

  AST_HOLD_FOR_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (state == WS_RECV && !known) |-> $stable(rel_ptr));  // R4

  AST_RD_FROM_AVAIL: assert property (@(posedge clk) disable iff (rst)
    rd_dv |-> $past(frame_avail));  // R9

endmodule

bind rxq_fwd_gate rxq_fwd_gate_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst),
  .frame_avail(frame_avail), .rd_dv(rd_dv),
  .wr_ptr(wr_ptr_w), .rel_ptr(rel_ptr_w), .rd_ptr(rd_ptr_w),
  .state(st_w), .known(known_w), .cut_act(cut_w)
);

// File: tb/rxq_fwd_gate_bench.sv
`timescale 1ns/1ps
module rxq_fwd_gate_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_cut_thru, flush_req, wr_valid, wr_last, flt_valid, flt_pass, rd_en;
  logic [1:0] cfg_thr_sel;
  logic [7:0] wr_data, rd_data;
  logic       rd_dv, rd_last, rd_err, frame_avail, drop_pulse;

  always #4 clk = ~clk;

  rxq_fwd_gate u_rxq_fwd_gate (
    .clk(clk), .rst(rst),
    .cfg_cut_thru(cfg_cut_thru), .cfg_thr_sel(cfg_thr_sel),
    .flush_req(flush_req),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .flt_valid(flt_valid), .flt_pass(flt_pass),
    .rd_en(rd_en), .rd_dv(rd_dv), .rd_data(rd_data),
    .rd_last(rd_last), .rd_err(rd_err),
    .frame_avail(frame_avail), .drop_pulse(drop_pulse)
  );

  int total = 0;
  int bad   = 0;
  int drop_cnt = 0;

  logic [7:0] got_d [1024];
  logic       got_l [1024];
  logic       got_e [1024];

  // cut, sel, len, verdict byte (0 = none), pass, expected release byte (0 = never)
  typedef struct packed {
    logic        cut;
    logic [1:0]  sel;
    logic [15:0] len;
    logic [15:0] vpos;
    logic        pass;
    logic [15:0] rise;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 16'd40,  16'd5,  1'b1, 16'd40},  // R2 whole frame
    '{1'b1, 2'd0, 16'd50,  16'd3,  1'b1, 16'd32},  // R3 thr 32
    '{1'b1, 2'd1, 16'd100, 16'd10, 1'b1, 16'd64},  // R3 thr 64
    '{1'b1, 2'd0, 16'd60,  16'd45, 1'b1, 16'd45},  // R4 late verdict
    '{1'b1, 2'd3, 16'd70,  16'd2,  1'b1, 16'd70},  // R3 short frame
    '{1'b1, 2'd0, 16'd50,  16'd40, 1'b0, 16'd0},   // R5 reject after thr
    '{1'b0, 2'd0, 16'd20,  16'd20, 1'b0, 16'd0},   // R5 reject on last
    '{1'b1, 2'd2, 16'd120, 16'd96, 1'b1, 16'd96},  // R3 verdict at thr 96
    '{1'b0, 2'd0, 16'd1,   16'd1,  1'b1, 16'd1},   // R2 one-byte frame
    '{1'b1, 2'd0, 16'd40,  16'd0,  1'b1, 16'd0},   // R5 no verdict
    '{1'b1, 2'd0, 16'd31,  16'd1,  1'b1, 16'd31}   // R3 one below thr
  };

  always @(posedge clk) if (!rst && drop_pulse) drop_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input logic last,
                           input logic fv, input logic fp);
    wr_valid = 1'b1; wr_data = d; wr_last = last; flt_valid = fv; flt_pass = fp;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0; flt_valid = 1'b0; flt_pass = 1'b0;
  endtask

  task automatic send_frame(input logic cut, input logic [1:0] sel, input int len,
                            input int vpos, input logic pass, input int seed,
                            output int rise);
    cfg_cut_thru = cut;
    cfg_thr_sel  = sel;
    rise = 0;
    for (int i = 1; i <= len; i++) begin
      send_byte(8'(seed + i), i == len, i == vpos, pass);
      if (frame_avail && rise == 0) rise = i;
    end
  endtask

  task automatic drain(output int n);
    n = 0;
    rd_en = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (rd_dv) begin
        got_d[n] = rd_data; got_l[n] = rd_last; got_e[n] = rd_err;
        n++;
      end
      if (!frame_avail && !rd_dv) break;
      rd_en = frame_avail;
    end
    rd_en = 1'b0;
  endtask

  // Checks count, order, end-of-frame marker and error flag of a clean frame
  task automatic check_frame(input string tag, input int n, input int len, input int seed);
    int errs = 0;
    chk({tag, " word count"}, n, len);
    for (int j = 0; j < n && j < len; j++) begin
      if (got_d[j] != 8'(seed + j + 1)) errs++;
      if (got_l[j] != (j == len - 1)) errs++;
      if (got_e[j] != 1'b0) errs++;
    end
    chk({tag, " data/last"}, errs, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int rise, n, d0, dvc;
    string tag;
    rst = 1'b1;
    cfg_cut_thru = 1'b0; cfg_thr_sel = 2'd0; flush_req = 1'b0;
    wr_valid = 1'b0; wr_data = '0; wr_last = 1'b0;
    flt_valid = 1'b0; flt_pass = 1'b0; rd_en = 1'b0;
    idle(5);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 frame_avail", int'(frame_avail), 0);
    chk("R1 rd_dv", int'(rd_dv), 0);
    chk("R1 drop_pulse", int'(drop_pulse), 0);

    // R9 read request with nothing available
    dvc = 0;
    rd_en = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (rd_dv) dvc++;
    end
    rd_en = 1'b0;
    chk("R9 read while empty", dvc, 0);

    // Table of frames
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].vpos == 0 || !VECS[v].pass) tag = "R5";
      else if (!VECS[v].cut) tag = "R2";
      else if (int'(VECS[v].vpos) > 32 * (int'(VECS[v].sel) + 1)) tag = "R4";
      else tag = "R3";
      d0 = drop_cnt;
      send_frame(VECS[v].cut, VECS[v].sel, int'(VECS[v].len), int'(VECS[v].vpos),
                 VECS[v].pass, v * 16, rise);
      idle(3);
      chk($sformatf("%s vec%0d release byte", tag, v), rise, int'(VECS[v].rise));
      chk($sformatf("%s vec%0d drop count", tag, v), drop_cnt - d0,
          (VECS[v].rise == 0) ? 1 : 0);
      drain(n);
      if (VECS[v].rise != 0)
        check_frame($sformatf("R9 vec%0d", v), n, int'(VECS[v].len), v * 16);
      else
        chk($sformatf("R5 vec%0d nothing readable", v), n, 0);
    end

    // R6 flush mid-frame, then flush between frames
    d0 = drop_cnt;
    cfg_cut_thru = 1'b0;
    for (int i = 1; i <= 10; i++) send_byte(8'(i), 1'b0, i == 2, 1'b1);
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
    for (int i = 11; i <= 20; i++) send_byte(8'(i), i == 20, 1'b0, 1'b0);
    idle(3);
    chk("R6 flushed frame not readable", int'(frame_avail), 0);
    flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
    idle(3);
    chk("R6 one drop for flush, none when idle", drop_cnt - d0, 1);
    send_frame(1'b0, 2'd0, 8, 1, 1'b1, 8'h50, rise);
    idle(2);
    chk("R6 next frame release", rise, 8);
    drain(n);
    check_frame("R6 next frame", n, 8, 8'h50);

    // R10 mode latched at first byte: starts store-and-forward, cfg flips after
    cfg_cut_thru = 1'b0; cfg_thr_sel = 2'd0;
    send_byte(8'h61, 1'b0, 1'b0, 1'b0);
    cfg_cut_thru = 1'b1;
    rise = 0;
    for (int i = 2; i <= 40; i++) begin
      send_byte(8'(8'h60 + i), i == 40, i == 2, 1'b1);
      if (frame_avail && rise == 0) rise = i;
    end
    idle(2);
    chk("R10 latched mode release byte", rise, 40);
    drain(n);
    check_frame("R10 frame", n, 40, 8'h60);

    // R7 overflow of an unreleased frame
    d0 = drop_cnt;
    send_frame(1'b0, 2'd0, 300, 1, 1'b1, 8'h10, rise);
    idle(3);
    chk("R7 overflow release byte", rise, 0);
    chk("R7 overflow drop count", drop_cnt - d0, 1);
    drain(n);
    chk("R7 overflow nothing readable", n, 0);
    send_frame(1'b0, 2'd0, 5, 5, 1'b1, 8'h20, rise);
    idle(2);
    drain(n);
    check_frame("R7 recovery frame", n, 5, 8'h20);

    // R8 overflow of a released cut-through frame
    d0 = drop_cnt;
    send_frame(1'b1, 2'd0, 300, 1, 1'b1, 8'h30, rise);
    idle(3);
    chk("R8 release byte", rise, 32);
    chk("R8 drop count", drop_cnt - d0, 1);
    drain(n);
    chk("R8 word count", n, 257);
    begin
      int errs = 0;
      for (int j = 0; j < 256; j++) begin
        if (got_d[j] != 8'(8'h30 + j + 1)) errs++;
        if (got_l[j] || got_e[j]) errs++;
      end
      chk("R8 kept bytes", errs, 0);
    end
    chk("R8 terminator err", int'(got_e[256]), 1);
    chk("R8 terminator last", int'(got_l[256]), 1);
    chk("R8 terminator data", int'(got_d[256]), 0);
    send_frame(1'b0, 2'd0, 6, 3, 1'b1, 8'h40, rise);
    idle(2);
    drain(n);
    check_frame("R8 following frame", n, 6, 8'h40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule